// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns bytes written into a small queue into asynchronous serial frames on a single output line. A producer presents a byte with a one-cycle push strobe; the byte waits in the queue until the line is free, then is sent as a low start bit, 5 to 8 data bits least significant first, an optional parity bit and one or two high stop bits. Bit timing comes from an external strobe that pulses at eight times the baud rate, so one bit occupies eight strobes.

The producer watches a full flag and a fill level to pace its writes, and an empty flag to know when the line has gone quiet after the last stop bit. An optional clear-to-send input from the far end can hold back the start of each new frame. A global enable switches the block off, which forces the line high and discards anything still queued.

Top module: `sertx_top`

## Requirements
- R1: A frame is a low start bit, then the data bits least significant first, then the parity bit when enabled, then one high stop bit (`two_stop`=0) or two (`two_stop`=1); `data_bits` codes 0, 1, 2, 3 select 5, 6, 7, 8 data bits; the line is high between frames.
- R2: `full` is high while `DEPTH` bytes wait in the queue; a push while `full` is high discards the byte and sets `tx_err`, which stays high until reset or until `enable` is cleared.
- R3: `level` equals the bytes waiting in the queue plus one while a frame is on the line, so it returns to 0 only after every pushed byte has been sent.
- R4: `empty` is high only when the queue holds nothing and no frame is in progress; it stays low until the final stop bit of the last frame has finished.
- R5: `parity_mode` codes: 0 no parity, 1 odd (data plus parity bit carry an odd count of ones), 2 even, 3 parity bit always 1, 4 parity bit always 0; codes 5 to 7 behave as 0.
- R6: With `flow_en`=1 a frame starts only while `cts` is high, and dropping `cts` mid-frame lets that frame finish; with `flow_en`=0 the value of `cts` has no effect.
- R7: Every level change of `txd` while enabled follows a cycle with `tick` high, each bit lasts eight ticks, and a queued byte starts immediately after the previous frame's last stop bit with no idle gap.
- R8: With `enable`=0 the line is high, the queue is emptied, `level` is 0, `tx_err` is cleared and pushes are ignored.
- R9: The format inputs (`data_bits`, `parity_mode`, `two_stop`) are captured at the start of each frame; changing them mid-frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global enable; 0 idles the line and flushes the queue |
| tick | input | 1 | Strobe at eight times the baud rate |
| push | input | 1 | Write strobe for `push_data` |
| push_data | input | 8 | Byte to queue |
| data_bits | input | 2 | Data length code, 0..3 for 5..8 bits |
| parity_mode | input | 3 | Parity code, see R5 |
| two_stop | input | 1 | 1 selects two stop bits |
| flow_en | input | 1 | 1 gates each frame start on `cts` |
| cts | input | 1 | Far end ready to receive, active high |
| txd | output | 1 | Serial line |
| full | output | 1 | Queue cannot accept another byte |
| empty | output | 1 | Nothing queued and line idle |
| level | output | 6 | Bytes not yet completely sent |
| tx_err | output | 1 | Sticky flag: a byte was pushed while full |

## Verification
The bench builds the block with `DEPTH` set to 32, the larger of the two supported depths, so that filling the queue while flow control holds the line drives `level` to 32 and exercises its top bit, and the overflow push happens on the 33rd byte. The tick strobe runs at half the clock rate, which makes a bit sixteen clocks long and puts the tick gating of every line transition within reach of the frame checks. The same depth lets one pending frame plus a full-minus-one queue show the level counting the in-flight byte.

// File: rtl/sertx_pkg.sv
// Package: shared encodings for the buffered serial transmitter.
// Assumes: parity codes outside the named set mean "no parity".
package sertx_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_ONE   = 3'd3,
        PAR_ZERO  = 3'd4
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    localparam int unsigned TICKS_PER_BIT = 8;
    localparam int unsigned BYTE_W        = 8;

endpackage

// File: rtl/sertx_fifo.sv
// Module: byte queue in front of the serializer.
// Holds up to DEPTH bytes; a push while full is dropped and flagged on
// `overflow` for the same cycle. A synchronous flush empties it.
// Assumes: DEPTH is a power of two (16 or 32).
module sertx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          is_empty,
    output logic          overflow
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          wr_ok;
    logic          rd_ok;

    assign full     = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign wr_ok    = push && !full && !flush;
    assign rd_ok    = pop && !is_empty && !flush;
    assign overflow = push && full && !flush;
    assign rdata    = mem[rd_ptr];

    // Storage write: store an accepted byte at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/sertx_shifter.sv
// Module: frame serializer.
// Starts a frame on a tick when a byte is available (and, under flow
// control, the far end is ready), captures the format for that frame,
// and steps through start, data, parity and stop bits, eight ticks each.
// Assumes: fifo_data is valid whenever fifo_avail is high.
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              fifo_avail,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic [1:0]        data_bits,
    input  logic [2:0]        parity_mode,
    input  logic              two_stop,
    input  logic              flow_en,
    input  logic              cts,
    output logic              pop,
    output logic              busy,
    output logic              txd
);

    localparam int unsigned TCW = $clog2(TICKS_PER_BIT);

    tx_state_e         state;
    logic [TCW-1:0]    tcnt;
    logic [2:0]        bidx;
    logic [2:0]        last_idx;
    logic [BYTE_W-1:0] shreg;
    logic              par_bit;
    logic              par_on;
    logic              stop2;
    logic              stop_idx;

    logic              bit_end;
    logic              frame_end;
    logic              can_go;
    logic              launch;
    logic [BYTE_W-1:0] data_mask;
    logic              data_xor;
    logic              next_par;
    logic              next_par_on;

    assign bit_end   = tick && (tcnt == TCW'(TICKS_PER_BIT - 1));
    assign frame_end = (state == ST_STOP) && bit_end && (stop_idx == stop2);
    assign can_go    = enable && fifo_avail && (!flow_en || cts);
    assign launch    = tick && can_go && ((state == ST_IDLE) || frame_end);
    assign pop       = launch;
    assign busy      = (state != ST_IDLE);

    // Parity of the data bits that will actually be sent.
    always_comb begin
        data_mask = 8'hFF >> (3'd3 - {1'b0, data_bits});
        data_xor  = ^(fifo_data & data_mask);
        case (par_e'(parity_mode))
            PAR_ODD:  begin next_par = ~data_xor; next_par_on = 1'b1; end
            PAR_EVEN: begin next_par = data_xor;  next_par_on = 1'b1; end
            PAR_ONE:  begin next_par = 1'b1;      next_par_on = 1'b1; end
            PAR_ZERO: begin next_par = 1'b0;      next_par_on = 1'b1; end
            default:  begin next_par = 1'b0;      next_par_on = 1'b0; end
        endcase
    end

    // Frame sequencer: launch captures the byte and format, ticks advance bits.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state    <= ST_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            last_idx <= 3'd7;
            shreg    <= '0;
            par_bit  <= 1'b0;
            par_on   <= 1'b0;
            stop2    <= 1'b0;
            stop_idx <= 1'b0;
        end else if (launch) begin
            state    <= ST_START;
            tcnt     <= '0;
            bidx     <= '0;
            last_idx <= {1'b0, data_bits} + 3'd4;
            shreg    <= fifo_data;
            par_bit  <= next_par;
            par_on   <= next_par_on;
            stop2    <= two_stop;
            stop_idx <= 1'b0;
        end else if (tick && state != ST_IDLE) begin
            if (!bit_end) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bidx == last_idx) begin
                            state    <= par_on ? ST_PAR : ST_STOP;
                            stop_idx <= 1'b0;
                        end else begin
                            bidx <= bidx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        state    <= ST_STOP;
                        stop_idx <= 1'b0;
                    end
                    ST_STOP: begin
                        if (stop_idx == stop2) state <= ST_IDLE;
                        else                   stop_idx <= 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Line level for the current bit.
    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    // R8
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> txd);

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && flow_en && !cts && state == ST_IDLE) |=> (state == ST_IDLE));

    // R7
    tick_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && !$stable(txd)) |-> $past(tick));

endmodule

// File: rtl/sertx_top.sv
// Module: buffered asynchronous serial transmitter (top).
// Queues pushed bytes and sends them as start/data/parity/stop frames
// paced by an eight-times-baud tick. Reports queue full, line empty,
// fill level (queued plus in flight) and a sticky overflow flag.
// Assumes: DEPTH is 16 or 32 so the level fits in six bits.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH) + 1,
    localparam int unsigned LW   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic [1:0]        data_bits,
    input  logic [2:0]        parity_mode,
    input  logic              two_stop,
    input  logic              flow_en,
    input  logic              cts,
    output logic              txd,
    output logic              full,
    output logic              empty,
    output logic [LW-1:0]     level,
    output logic              tx_err
);

    logic [BYTE_W-1:0] q_data;
    logic [CW-1:0]     q_count;
    logic              q_empty;
    logic              q_overflow;
    logic              q_pop;
    logic              busy;

    sertx_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!enable),
        .push     (push),
        .wdata    (push_data),
        .pop      (q_pop),
        .rdata    (q_data),
        .count    (q_count),
        .full     (full),
        .is_empty (q_empty),
        .overflow (q_overflow)
    );

    sertx_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .tick        (tick),
        .fifo_avail  (!q_empty),
        .fifo_data   (q_data),
        .data_bits   (data_bits),
        .parity_mode (parity_mode),
        .two_stop    (two_stop),
        .flow_en     (flow_en),
        .cts         (cts),
        .pop         (q_pop),
        .busy        (busy),
        .txd         (txd)
    );

    assign empty = q_empty && !busy;
    assign level = LW'(q_count) + LW'(busy);

    // Sticky overflow flag, cleared by reset or by disabling the block.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) tx_err <= 1'b0;
        else if (q_overflow)   tx_err <= 1'b1;
    end

    // R4
    empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (level == '0));

    // R3
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH + 1));

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_err && enable) |=> tx_err);

endmodule

// File: tb/sim_sertx_top.sv
module sim_sertx_top;

    localparam int DEPTH = 32;
    // {data[13:6], data_bits[5:4], parity_mode[3:1], two_stop[0]}
    localparam logic [13:0] VEC [6] = '{
        {8'hA5, 2'd3, 3'd0, 1'b0},
        {8'h13, 2'd0, 3'd1, 1'b0},
        {8'h2C, 2'd1, 3'd2, 1'b1},
        {8'h7F, 2'd2, 3'd3, 1'b0},
        {8'h80, 2'd3, 3'd4, 1'b1},
        {8'h55, 2'd3, 3'd6, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       tick;
    logic       push = 1'b0;
    logic [7:0] push_data = '0;
    logic [1:0] data_bits = 2'd3;
    logic [2:0] parity_mode = 3'd0;
    logic       two_stop = 1'b0;
    logic       flow_en = 1'b0;
    logic       cts = 1'b0;
    logic       txd, full, empty, tx_err;
    logic [5:0] level;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int waited = 0;

    sertx_top #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .push(push), .push_data(push_data), .data_bits(data_bits),
        .parity_mode(parity_mode), .two_stop(two_stop), .flow_en(flow_en),
        .cts(cts), .txd(txd), .full(full), .empty(empty), .level(level),
        .tx_err(tx_err)
    );

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_byte(input logic [7:0] d);
        @(negedge clk);
        push = 1'b1;
        push_data = d;
        @(negedge clk);
        push = 1'b0;
    endtask

    // Waits for a start bit, samples each bit centre, compares to the frame
    // the requirements predict. Returns at the centre of the last stop bit.
    task automatic expect_frame(input logic [7:0] d, input logic [1:0] nb,
                                input logic [2:0] pm, input logic st2,
                                input string req);
        logic [11:0] exp_v = '0;
        logic [11:0] got_v = '0;
        int n = int'(nb) + 5;
        int len;
        logic ones = 1'b0;
        for (int i = 0; i < n; i++) begin
            exp_v[1+i] = d[i];
            ones = ones ^ d[i];
        end
        len = 1 + n;
        if (pm >= 3'd1 && pm <= 3'd4) begin
            case (pm)
                3'd1: exp_v[len] = ~ones;
                3'd2: exp_v[len] = ones;
                3'd3: exp_v[len] = 1'b1;
                default: exp_v[len] = 1'b0;
            endcase
            len = len + 1;
        end
        exp_v[len] = 1'b1;
        len = len + 1;
        if (st2) begin
            exp_v[len] = 1'b1;
            len = len + 1;
        end
        waited = 0;
        do begin
            @(negedge clk);
            waited = waited + 1;
        end while (txd && waited < 3000);
        if (txd) begin
            check(1'b0, req, 1, 0);
            return;
        end
        repeat (8) @(negedge clk);
        got_v[0] = txd;
        for (int i = 1; i < len; i++) begin
            repeat (16) @(negedge clk);
            got_v[i] = txd;
        end
        check(got_v == exp_v, req, int'(got_v), int'(exp_v));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R1 idle line, R2, R3, R4)
        check(txd == 1'b1, "R1 idle high", int'(txd), 1);
        check(empty == 1'b1 && full == 1'b0, "R4 reset empty", int'({empty, full}), 2);
        check(level == 6'd0 && tx_err == 1'b0, "R3 reset level", int'({tx_err, level}), 0);

        // Table of formats: R1 and R5
        foreach (VEC[k]) begin
            data_bits   = VEC[k][5:4];
            parity_mode = VEC[k][3:1];
            two_stop    = VEC[k][0];
            push_byte(VEC[k][13:6]);
            expect_frame(VEC[k][13:6], VEC[k][5:4], VEC[k][3:1], VEC[k][0], "R1_R5 table frame");
            repeat (20) @(negedge clk);
            check(empty == 1'b1, "R4 empty after frame", int'(empty), 1);
        end
        data_bits = 2'd3; parity_mode = 3'd0; two_stop = 1'b0;

        // R9: change format mid-frame
        push_byte(8'hC3);
        fork
            expect_frame(8'hC3, 2'd3, 3'd0, 1'b0, "R9 format latched");
            begin
                repeat (40) @(negedge clk);
                data_bits = 2'd0; parity_mode = 3'd1; two_stop = 1'b1;
            end
        join
        repeat (20) @(negedge clk);
        data_bits = 2'd3; parity_mode = 3'd0; two_stop = 1'b0;

        // R7 back-to-back and R4 empty timing
        push_byte(8'h11);
        push_byte(8'h22);
        expect_frame(8'h11, 2'd3, 3'd0, 1'b0, "R7 first of pair");
        check(empty == 1'b0, "R4 busy during stop", int'(empty), 0);
        expect_frame(8'h22, 2'd3, 3'd0, 1'b0, "R7 second of pair");
        check(waited <= 8, "R7 no idle gap", waited, 8);
        check(empty == 1'b0, "R4 empty low in final stop", int'(empty), 0);
        repeat (12) @(negedge clk);
        check(empty == 1'b1 && level == 6'd0, "R4 empty after last stop", int'({empty, level}), 64);

        // R6 flow control hold, R2 full/overflow, R3 level
        flow_en = 1'b1; cts = 1'b0;
        for (int i = 0; i < DEPTH; i++) push_byte(8'h40 + 8'(i));
        begin
            int lows = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (!txd) lows++;
            end
            check(lows == 0, "R6 held by cts", lows, 0);
        end
        check(level == 6'd32, "R3 level at depth", int'(level), 32);
        check(full == 1'b1 && empty == 1'b0, "R2 full flag", int'({full, empty}), 2);
        push_byte(8'hEE);
        check(tx_err == 1'b1, "R2 overflow flag", int'(tx_err), 1);
        check(level == 6'd32, "R2 byte dropped", int'(level), 32);
        cts = 1'b1;
        expect_frame(8'h40, 2'd3, 3'd0, 1'b0, "R6 release by cts");
        check(level == 6'd32 && full == 1'b0, "R3 level counts in-flight", int'({full, level}), 32);
        check(tx_err == 1'b1, "R2 error sticky", int'(tx_err), 1);
        fork
            expect_frame(8'h41, 2'd3, 3'd0, 1'b0, "R6 frame completes after cts drop");
            begin
                repeat (30) @(negedge clk);
                cts = 1'b0;
            end
        join
        begin
            int lows = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (!txd) lows++;
            end
            check(lows == 0, "R6 no new frame without cts", lows, 0);
        end
        check(level == 6'd30, "R3 level after two sent", int'(level), 30);

        // R8 disable flushes
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        check(level == 6'd0 && empty == 1'b1 && full == 1'b0, "R8 flushed",
              int'({full, empty, level}), 64);
        check(txd == 1'b1 && tx_err == 1'b0, "R8 idle and error cleared", int'({txd, tx_err}), 2);
        push_byte(8'h99);
        check(level == 6'd0, "R8 push ignored", int'(level), 0);
        enable = 1'b1;
        repeat (40) @(negedge clk);
        check(txd == 1'b1 && level == 6'd0, "R8 nothing left after enable", int'({txd, level}), 64);

        // R6 cts ignored without flow control
        flow_en = 1'b0; cts = 1'b0;
        push_byte(8'h5A);
        expect_frame(8'h5A, 2'd3, 3'd0, 1'b0, "R6 cts ignored");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule